// File: doc/BRIEF.md
# Sixteen-Source Interrupt Concentrator

The block merges sixteen peripheral request lines into a single request line for an upstream interrupt controller. Sources 0 to 7 form the level group. Sources 8 to 15 form the system group. Every source has a sticky pending bit: the bit is set on any cycle in which its input is high, and it stays set until software writes 1 to it. Each source also has an enable bit. A pending bit affects the output only while its enable bit is set.

Software uses a byte-wide register port with an address, a write strobe, write data and combinational read data. Once the output line has risen, it stays high for the whole interrupt episode. Only a write to the end-of-interrupt register brings it low. This gives the upstream controller one clean rising edge per episode. Four edge-control registers are present, but they only store values and never affect the output.

Register offsets (byte addresses; odd addresses are holes):

| Offset | Function |
|---|---|
| 0x00 | end-of-interrupt |
| 0x02 | live inputs of the level group |
| 0x04 | system-group enables |
| 0x06 | system pending, upper bits |
| 0x08 | system pending, lower bits |
| 0x0A, 0x0C | rising-edge storage |
| 0x0E | level-group enables |
| 0x10 | level pending |
| 0x12, 0x14 | falling-edge storage |

Top module: `irq_concentrator`

## Requirements
- R1: After reset, irq_o is low and every register offset reads 0x00 while all inputs are low.
- R2: A high level on src_i[n], for n from 0 to 7, held for at least one clock edge, sets bit n of offset 0x10. The bit stays set after the input falls.
- R3: Writing 1 to a bit of offset 0x10, 0x08 or 0x06 clears that pending bit. Writing 0 leaves the bit unchanged. If the source input is still high in the cycle of the clearing write, the bit stays set.
- R4: The pending bit of source 8+k reads at bit k of offset 0x08 when k is 0 to 4, and at bit k of offset 0x06 when k is 5 to 7. The remaining bits of these two offsets read 0.
- R5: Bit n of offset 0x0E enables source n, and bit k of offset 0x04 enables source 8+k. Both offsets read back the value last written. A pending bit that is not enabled never raises irq_o.
- R6: irq_o goes high at the clock edge that follows the first cycle in which an enabled pending bit exists. It then stays high until an end-of-interrupt write, even if the pending bits are cleared.
- R7: A write of any value to offset 0x00 drives irq_o low at that clock edge. If enabled pending bits still exist, irq_o rises again one edge later. Otherwise it stays low. Offset 0x00 reads 0.
- R8: Offsets 0x0A, 0x0C, 0x12 and 0x14 read back the last value written to them, and they have no effect on irq_o.
- R9: Odd offsets, and offsets 0x16 and above, read 0x00. Writes to them change no register and do not affect irq_o.
- R10: The initialisation sequence writes 0x00 to offsets 0x0C, 0x0A, 0x14, 0x12, 0x10, 0x0E, 0x04 and 0x08. This sequence leaves irq_o low.
- R11: Offset 0x02 returns the live value of src_i[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled at the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| src_i | input | 16 | Source request lines, active high |
| irq_o | output | 1 | Aggregated request to the upstream controller |

## Verification
The bench builds the block with the default ADDR_W of 5. With this value the bench can reach the whole 32-byte address space: every odd hole and every offset above the 0x16-byte window is a legal stimulus address. Random accesses therefore exercise the ignore rules together with the real registers. Random sparse pulses on the sources, mixed with random end-of-interrupt writes and clearing writes, cover these cases:
- the output holding high after its pending bits have been cleared;
- the output reasserting right after an end-of-interrupt write;
- a clearing write landing in the same cycle as a still-high input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W    = 8;
  localparam int GRP_N    = 8;
  localparam int SRC_N    = 2 * GRP_N;
  localparam int SEC_BITS = 5;
  localparam int PRI_BITS = GRP_N - SEC_BITS;
  localparam int EDGE_N   = 4;

  localparam int OFS_EOI   = 'h00;
  localparam int OFS_INPUT = 'h02;
  localparam int OFS_SYSEN = 'h04;
  localparam int OFS_PRI   = 'h06;
  localparam int OFS_SEC   = 'h08;
  localparam int OFS_LVLEN = 'h0E;
  localparam int OFS_LVL   = 'h10;

  localparam int EDGE_OFS [EDGE_N] = '{'h0A, 'h0C, 'h12, 'h14};
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    // set dominates clear: a still-high source keeps its bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= src_i[i] | (q & ~clr_i[i]);
    end
    assign pend_o[i] = q;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [GRP_N-1:0]  lvl_src_i,
  input  logic [GRP_N-1:0]  lvl_pend_i,
  input  logic [GRP_N-1:0]  sys_pend_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [GRP_N-1:0]  lvl_en_o,
  output logic [GRP_N-1:0]  sys_en_o,
  output logic [GRP_N-1:0]  lvl_clr_o,
  output logic [GRP_N-1:0]  sys_clr_o,
  output logic              eoi_o
);
  logic hit_eoi, hit_in, hit_sysen, hit_pri, hit_sec, hit_lvlen, hit_lvl;
  logic [EDGE_N-1:0] hit_edge;

  assign hit_eoi   = (addr_i == ADDR_W'(OFS_EOI));
  assign hit_in    = (addr_i == ADDR_W'(OFS_INPUT));
  assign hit_sysen = (addr_i == ADDR_W'(OFS_SYSEN));
  assign hit_pri   = (addr_i == ADDR_W'(OFS_PRI));
  assign hit_sec   = (addr_i == ADDR_W'(OFS_SEC));
  assign hit_lvlen = (addr_i == ADDR_W'(OFS_LVLEN));
  assign hit_lvl   = (addr_i == ADDR_W'(OFS_LVL));

  logic [GRP_N-1:0] lvl_en_q, sys_en_q;
  logic [REG_W-1:0] edge_q [EDGE_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_en_q <= '0;
      sys_en_q <= '0;
    end else if (we_i) begin
      if (hit_lvlen) lvl_en_q <= wdata_i;
      if (hit_sysen) sys_en_q <= wdata_i;
    end
  end

  // edge-control storage: held inert, readable only
  for (genvar e = 0; e < EDGE_N; e++) begin : g_edge
    assign hit_edge[e] = (addr_i == ADDR_W'(EDGE_OFS[e]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 edge_q[e] <= '0;
      else if (we_i && hit_edge[e]) edge_q[e] <= wdata_i;
    end
  end

  assign lvl_en_o  = lvl_en_q;
  assign sys_en_o  = sys_en_q;
  assign eoi_o     = we_i & hit_eoi;
  assign lvl_clr_o = (we_i && hit_lvl) ? wdata_i : '0;
  assign sys_clr_o[SEC_BITS-1:0] = (we_i && hit_sec) ? wdata_i[SEC_BITS-1:0] : '0;
  assign sys_clr_o[GRP_N-1:SEC_BITS] = (we_i && hit_pri) ? wdata_i[GRP_N-1:SEC_BITS] : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_in)    rdata_o = lvl_src_i;
    if (hit_sysen) rdata_o = sys_en_q;
    if (hit_pri)   rdata_o = {sys_pend_i[GRP_N-1:SEC_BITS], {SEC_BITS{1'b0}}};
    if (hit_sec)   rdata_o = {{PRI_BITS{1'b0}}, sys_pend_i[SEC_BITS-1:0]};
    if (hit_lvlen) rdata_o = lvl_en_q;
    if (hit_lvl)   rdata_o = lvl_pend_i;
    for (int e = 0; e < EDGE_N; e++) begin
      if (hit_edge[e]) rdata_o = edge_q[e];
    end
  end
endmodule

// File: rtl/irqc_out.sv
module irqc_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic irq_q;
  // held for the whole episode; only end-of-interrupt drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (eoi_i) irq_q <= 1'b0;
    else            irq_q <= irq_q | active_i;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [SRC_N-1:0]  src_i,
  output logic              irq_o
);
  logic [GRP_N-1:0] lvl_pend, sys_pend, lvl_en, sys_en, lvl_clr, sys_clr;
  logic eoi, any_active;

  irqc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .lvl_src_i (src_i[GRP_N-1:0]),
    .lvl_pend_i(lvl_pend),
    .sys_pend_i(sys_pend),
    .rdata_o,
    .lvl_en_o  (lvl_en),
    .sys_en_o  (sys_en),
    .lvl_clr_o (lvl_clr),
    .sys_clr_o (sys_clr),
    .eoi_o     (eoi)
  );

  irqc_pend #(.N(GRP_N)) u_lvl (
    .clk_i, .rst_ni, .src_i(src_i[GRP_N-1:0]), .clr_i(lvl_clr), .pend_o(lvl_pend)
  );

  irqc_pend #(.N(GRP_N)) u_sys (
    .clk_i, .rst_ni, .src_i(src_i[SRC_N-1:GRP_N]), .clr_i(sys_clr), .pend_o(sys_pend)
  );

  assign any_active = |{lvl_pend & lvl_en, sys_pend & sys_en};

  irqc_out u_out (
    .clk_i, .rst_ni, .active_i(any_active), .eoi_i(eoi), .irq_o
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              irq_o,
  input logic              active_i,
  input logic [7:0]        lvl_pend_i
);
  logic eoi_wr, lvl_wr;
  assign eoi_wr = we_i && (addr_i == ADDR_W'(0));
  assign lvl_wr = we_i && (addr_i == ADDR_W'('h10));

  AST_EOI_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> !irq_o);                                              // R7
  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_wr) |=> irq_o);                                   // R6
  AST_ACTIVE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !eoi_wr) |=> irq_o);                                // R6
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(active_i));                               // R5
  AST_LVL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_wr |=> ((lvl_pend_i & $past(lvl_pend_i)) == $past(lvl_pend_i))); // R2
endmodule

bind irq_concentrator irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .irq_o(irq_o), .active_i(any_active), .lvl_pend_i(lvl_pend)
);

// File: tb/tb_irq_concentrator.sv
`timescale 1ns/1ps
module tb_irq_concentrator;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0, rdata;
  logic [15:0] src = '0;
  logic irq;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  irq_concentrator #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wd),
    .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  // reference state derived from the requirement text
  logic [7:0] m_lp, m_sp, m_le, m_se, m_e0, m_e1, m_e2, m_e3;
  logic m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lp <= 0; m_sp <= 0; m_le <= 0; m_se <= 0;
      m_e0 <= 0; m_e1 <= 0; m_e2 <= 0; m_e3 <= 0; m_irq <= 0;
    end else begin
      logic [7:0] lc, sc;
      lc = (we && addr == 5'h10) ? wd : 8'h0;
      sc = 8'h0;
      if (we && addr == 5'h08) sc[4:0] = wd[4:0];
      if (we && addr == 5'h06) sc[7:5] = wd[7:5];
      m_lp <= src[7:0] | (m_lp & ~lc);
      m_sp <= src[15:8] | (m_sp & ~sc);
      if (we && addr == 5'h0E) m_le <= wd;
      if (we && addr == 5'h04) m_se <= wd;
      if (we && addr == 5'h0A) m_e0 <= wd;
      if (we && addr == 5'h0C) m_e1 <= wd;
      if (we && addr == 5'h12) m_e2 <= wd;
      if (we && addr == 5'h14) m_e3 <= wd;
      if (we && addr == 5'h00) m_irq <= 1'b0;
      else m_irq <= m_irq | (|((m_lp & m_le) | (m_sp & m_se)));
    end
  end

  function automatic logic [7:0] exp_read(logic [AW-1:0] a);
    case (a)
      5'h02: return src[7:0];
      5'h04: return m_se;
      5'h06: return {m_sp[7:5], 5'b0};
      5'h08: return {3'b0, m_sp[4:0]};
      5'h0A: return m_e0;
      5'h0C: return m_e1;
      5'h0E: return m_le;
      5'h10: return m_lp;
      5'h12: return m_e2;
      5'h14: return m_e3;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic [AW-1:0] a);
    case (a)
      5'h10: return "R2";
      5'h06, 5'h08: return "R4";
      5'h04, 5'h0E: return "R5";
      5'h02: return "R11";
      5'h0A, 5'h0C, 5'h12, 5'h14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string req);
    addr = a; #1; chk(req, rdata, exp);
  endtask
  task automatic irq_is(logic e, string req);
    #1; chk(req, {7'b0, irq}, {7'b0, e});
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    irq_is(1'b0, "R1");
    for (int a = 0; a < 'h16; a += 2) rd(AW'(a), 8'h00, "R1");
    // R10 zero initialisation
    wr(5'h0C, 0); wr(5'h0A, 0); wr(5'h14, 0); wr(5'h12, 0);
    wr(5'h10, 0); wr(5'h0E, 0); wr(5'h04, 0); wr(5'h08, 0);
    irq_is(1'b0, "R10"); cyc(); irq_is(1'b0, "R10");
    // R2 sticky latch, not enabled
    src = 16'h0008; cyc(); src = 16'h0000; cyc();
    rd(5'h10, 8'h08, "R2");
    repeat (3) cyc();
    rd(5'h10, 8'h08, "R2");
    irq_is(1'b0, "R5");
    // R5/R6 enable then registered rise
    wr(5'h0E, 8'h08);
    rd(5'h0E, 8'h08, "R5");
    irq_is(1'b0, "R6");
    cyc(); irq_is(1'b1, "R6");
    // R3 write 0 keeps, write 1 clears, R6 holds
    wr(5'h10, 8'h00); rd(5'h10, 8'h08, "R3");
    wr(5'h10, 8'h08); rd(5'h10, 8'h00, "R3");
    irq_is(1'b1, "R6"); cyc(); irq_is(1'b1, "R6");
    // R7 EOI with nothing pending
    wr(5'h00, 8'h5A); irq_is(1'b0, "R7");
    cyc(); irq_is(1'b0, "R7");
    rd(5'h00, 8'h00, "R7");
    // R7 EOI with pending remaining, R3 set wins
    src = 16'h0008; cyc(); cyc(); irq_is(1'b1, "R6");
    wr(5'h10, 8'h08); rd(5'h10, 8'h08, "R3");
    wr(5'h00, 8'h00); irq_is(1'b0, "R7");
    cyc(); irq_is(1'b1, "R7");
    src = 16'h0000; cyc();
    wr(5'h10, 8'hFF); wr(5'h00, 8'h01); cyc(); irq_is(1'b0, "R7");
    // R4 system mapping
    for (int k = 0; k < 8; k++) begin
      src = 16'h0100 << k; cyc(); src = 16'h0; cyc();
      rd(5'h08, (k < 5) ? (8'h01 << k) : 8'h00, "R4");
      rd(5'h06, (k >= 5) ? (8'h01 << k) : 8'h00, "R4");
      irq_is(1'b0, "R5");
      wr(5'h08, 8'hFF); wr(5'h06, 8'hFF);
      rd(5'h08, 8'h00, "R3"); rd(5'h06, 8'h00, "R3");
    end
    // R5 system enable
    wr(5'h04, 8'h80); rd(5'h04, 8'h80, "R5");
    src = 16'h8000; cyc(); src = 16'h0; cyc(); irq_is(1'b1, "R5");
    wr(5'h06, 8'h80); wr(5'h00, 8'h00); cyc(); irq_is(1'b0, "R7");
    // R8 edge storage inert
    src = 16'h0001; cyc(); src = 16'h0;
    wr(5'h0A, 8'hA5); wr(5'h0C, 8'h3C); wr(5'h12, 8'hFF); wr(5'h14, 8'h81);
    rd(5'h0A, 8'hA5, "R8"); rd(5'h0C, 8'h3C, "R8");
    rd(5'h12, 8'hFF, "R8"); rd(5'h14, 8'h81, "R8");
    cyc(); irq_is(1'b0, "R8");
    // R9 holes ignored
    wr(5'h0F, 8'hFF); wr(5'h11, 8'hFF); wr(5'h18, 8'hFF); wr(5'h05, 8'hFF);
    rd(5'h0E, 8'h08, "R9"); rd(5'h04, 8'h80, "R9"); rd(5'h10, 8'h01, "R9");
    rd(5'h0F, 8'h00, "R9"); rd(5'h11, 8'h00, "R9"); rd(5'h1E, 8'h00, "R9");
    cyc(); irq_is(1'b0, "R9");
    // R11 live inputs
    src = 16'h005C; rd(5'h02, 8'h5C, "R11");
    src = 16'h0; cyc();
    // random phase against reference state
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      src = (($urandom % 5) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      we = (($urandom % 3) == 0);
      case ($urandom % 6)
        0: addr = 5'h00;
        1: addr = 5'h10;
        2: addr = (($urandom % 2) == 0) ? 5'h06 : 5'h08;
        3: addr = (($urandom % 2) == 0) ? 5'h04 : 5'h0E;
        default: addr = AW'($urandom);
      endcase
      wd = 8'($urandom);
      #1;
      chk(req_of(addr), rdata, exp_read(addr));
      chk("R6", {7'b0, irq}, {7'b0, m_irq});
    end
    @(negedge clk); we = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule